// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events from a set of transmit queues and from the host interface into a small hierarchy of status registers. Each per-queue event class has its own field, one bit per queue, in one of five secondary status registers. A single primary status register carries three directly set bits and nine summary bits, and each summary bit is the OR of one secondary field. Software clears status by writing ones, at either level. A write of one to a summary bit wipes every secondary bit behind that summary.

A primary mask, a per-field secondary mask and a global enable decide whether the collected status raises the interrupt line. The pending register reports whether any masked cause is active, whatever the global enable holds. The interrupt output is that pending term ANDed with the global enable. Register writes take effect at the clock edge. Reads are combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every status register, every mask register and the global enable read 0, and `irq_o` is 0.
- R2: A pulse on a per-queue event input sets bit q of its field on the next clock edge, and the bit then reads back at the fixed layout below (NQ = queue count, "low" = bits NQ-1:0, "high" = bits 2NQ-1:NQ). Secondary 0 (address 1) holds transmit-OK low and descriptor-done high. Secondary 1 (address 2) holds transmit-error low and end-of-list high. Secondary 2 (address 3) holds underrun low and the host errors at NQ+0 (master abort), NQ+1 (system error) and NQ+2 (parity). Secondary 3 (address 4) holds CBR-overrun low and CBR-underrun high. Secondary 4 (address 5) holds trigger low.
- R3: The primary status (address 0) has direct bits 0 (receive done), 1 (receive error) and 2 (beacon miss), set by `ev_prim`. Bits 3 to 10 are the ORs of the fields transmit-OK, descriptor-done, transmit-error, end-of-list, underrun, CBR-overrun, CBR-underrun and trigger, in that order. Bit 11 is the OR of the three host-error bits.
- R4: Writing a secondary register clears exactly the bits written as 1 and keeps the bits written as 0. Once a field has no bit set, its primary summary bit reads 0.
- R5: Writing 1 to a summary bit of the primary register clears every bit of its field and leaves all other fields untouched. Writing 1 to a direct primary bit clears only that bit.
- R6: An event that arrives in the same cycle as a clear of its bit, at either level, leaves the bit set.
- R7: The pending register (address 8, bit 0) reads 1 exactly when some primary bit p has its primary-mask bit set (address 6, bit p) and is active. A direct bit is active when its status is set. A summary bit is active when some bit of its field is set together with the matching bit of that field's secondary mask. The secondary masks (addresses 9 to 13) share the layout of secondary registers 0 to 4.
- R8: `irq_o` equals pending ANDed with the global enable (address 7, bit 0, 1 = enabled). Writing 0 there forces `irq_o` to 0 and leaves status and pending unchanged.
- R9: The mask and enable registers read back what was written, limited to their implemented bits. A write to the pending address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_prim | input | 3 | Direct primary events (bit 0 rx done, 1 rx error, 2 beacon miss) |
| ev_txok | input | NQ | Per-queue transmit-OK events |
| ev_desc | input | NQ | Per-queue descriptor-done events |
| ev_txerr | input | NQ | Per-queue transmit-error events |
| ev_eol | input | NQ | Per-queue end-of-list events |
| ev_urun | input | NQ | Per-queue underrun events |
| ev_cbro | input | NQ | Per-queue CBR-overrun events |
| ev_cbru | input | NQ | Per-queue CBR-underrun events |
| ev_trig | input | NQ | Per-queue trigger events |
| ev_host | input | 3 | Host errors (bit 0 master abort, 1 system error, 2 parity) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | DW | Combinational read data |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench sweeps every field and every queue one bit at a time. A field placed at the wrong offset or tied to the wrong summary bit would show up as a wrong read-back. Summary clears are tested with every other field fully set, so a clear that reaches into a neighbouring field would leave a visible gap. Events are made to coincide with clears at both levels, where a design that lets the clear win would lose the event. The mask sweep covers every primary bit with both mask levels on and off, plus a single-queue secondary mask. The global-enable test confirms that disabling silences `irq_o` while pending and status survive, which a design that cleared state on disable would fail.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and layout functions for the interrupt aggregator.
// Assumes: one field per per-queue event class; a secondary register holds at
// most two fields (low and high halves of width NQ).
package irq_agg_pkg;

    localparam int AW         = 4;
    localparam int NUM_DIRECT = 3;
    localparam int NUM_QF     = 8;
    localparam int HOST_W     = 3;
    localparam int NUM_SEC    = 5;
    localparam int PRIM_W     = NUM_DIRECT + NUM_QF + 1;
    localparam int HOST_BIT   = PRIM_W - 1;

    localparam int A_PSTAT  = 0;
    localparam int A_SEC0   = 1;
    localparam int A_PMASK  = 6;
    localparam int A_GEN    = 7;
    localparam int A_PEND   = 8;
    localparam int A_SMASK0 = 9;
    localparam int HOST_SEC = 2;

    // Secondary register index that holds per-queue field k.
    function automatic int qf_reg(input int k);
        case (k)
            0, 1:    return 0;
            2, 3:    return 1;
            4:       return 2;
            5, 6:    return 3;
            default: return 4;
        endcase
    endfunction

    // 1 when field k sits in the upper half of its register.
    function automatic int qf_hi(input int k);
        return (k == 1 || k == 3 || k == 6) ? 1 : 0;
    endfunction

    // Data width: wide enough for the primary register and every secondary.
    function automatic int agg_dw(input int nq);
        int w;
        w = PRIM_W;
        if (2 * nq > w) w = 2 * nq;
        if (nq + HOST_W > w) w = nq + HOST_W;
        return w;
    endfunction

endpackage

// File: rtl/irq_field.sv
// Module: one secondary status field with its own secondary mask.
// Status bits are write-one-to-clear, through the field's register address or
// through a summary clear from the primary register. A new event beats a clear.
// Assumes: wr_slice is already the field's slice of the write data.
module irq_field #(
    parameter int W         = 4,
    parameter int AW        = 4,
    parameter int ST_ADDR   = 1,
    parameter int MASK_ADDR = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  ev,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_slice,
    input  logic          sum_clr,
    output logic [W-1:0]  stat_o,
    output logic [W-1:0]  mask_o,
    output logic          any_raw_o,
    output logic          any_msk_o
);

    logic [W-1:0] clr_bits;

    // Collect the bits to clear this cycle from both clear paths.
    always_comb begin
        clr_bits = '0;
        if (wr_en && wr_addr == AW'(ST_ADDR)) clr_bits = wr_slice;
        if (sum_clr) clr_bits = '1;
    end

    // Status update: clear first, then OR in new events so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= (stat_o & ~clr_bits) | ev;
    end

    // Plain read/write secondary mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= '0;
        else if (wr_en && wr_addr == AW'(MASK_ADDR)) mask_o <= wr_slice;
    end

    // Field summaries, raw and qualified by the secondary mask.
    always_comb begin
        any_raw_o = |stat_o;
        any_msk_o = |(stat_o & mask_o);
    end

endmodule

// File: rtl/irq_summary.sv
// Module: builds the primary status view and the pending/interrupt terms.
// Assumes: field summaries arrive ordered as primary bits NUM_DIRECT upward.
module irq_summary #(
    parameter int ND  = 3,
    parameter int NSF = 9,
    localparam int PW = ND + NSF
) (
    input  logic [ND-1:0]  direct_stat,
    input  logic [NSF-1:0] f_raw,
    input  logic [NSF-1:0] f_msk,
    input  logic [PW-1:0]  pmask,
    input  logic           gen_en,
    output logic [PW-1:0]  pstat_o,
    output logic           pend_o,
    output logic           irq_o
);

    logic [PW-1:0] active;

    // Primary view uses raw summaries; activity honours the secondary masks.
    always_comb begin
        pstat_o = {f_raw, direct_stat};
        active  = {f_msk, direct_stat};
        pend_o  = |(active & pmask);
        irq_o   = pend_o & gen_en;
    end

endmodule

// File: rtl/irq_aggregator.sv
// Module: two-level interrupt status aggregator (top).
// Eight per-queue fields plus a host-error field feed nine primary summary
// bits; three direct primary bits are set by their own events. Registers
// are written by a single-cycle strobe and read combinationally.
// Assumes: synchronous active-low reset; event inputs are one-cycle pulses
// or levels, each high cycle re-asserting the bit.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int  NQ = 4,
    localparam int DW = agg_dw(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ev_prim,
    input  logic [NQ-1:0] ev_txok,
    input  logic [NQ-1:0] ev_desc,
    input  logic [NQ-1:0] ev_txerr,
    input  logic [NQ-1:0] ev_eol,
    input  logic [NQ-1:0] ev_urun,
    input  logic [NQ-1:0] ev_cbro,
    input  logic [NQ-1:0] ev_cbru,
    input  logic [NQ-1:0] ev_trig,
    input  logic [2:0]    ev_host,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_o
);

    localparam int NSF = NUM_QF + 1;

    logic [NQ-1:0]         qev    [NUM_QF];
    logic [NQ-1:0]         f_stat [NUM_QF];
    logic [NQ-1:0]         f_mask [NUM_QF];
    logic [NSF-1:0]        f_raw;
    logic [NSF-1:0]        f_msk;
    logic [NSF-1:0]        sum_clr;
    logic [HOST_W-1:0]     host_stat;
    logic [HOST_W-1:0]     host_mask;
    logic [NUM_DIRECT-1:0] direct_q;
    logic [PRIM_W-1:0]     pmask_q;
    logic                  gen_q;
    logic [PRIM_W-1:0]     pstat;
    logic                  pend;
    logic                  prim_wr;
    logic [DW-1:0]         sec_view  [NUM_SEC];
    logic [DW-1:0]         smsk_view [NUM_SEC];

    // Gather per-queue events in primary-bit order.
    always_comb begin
        qev[0] = ev_txok;
        qev[1] = ev_desc;
        qev[2] = ev_txerr;
        qev[3] = ev_eol;
        qev[4] = ev_urun;
        qev[5] = ev_cbro;
        qev[6] = ev_cbru;
        qev[7] = ev_trig;
    end

    // Decode a primary write and the summary clears it carries.
    always_comb begin
        prim_wr = wr_en && wr_addr == AW'(A_PSTAT);
        for (int k = 0; k < NSF; k++) sum_clr[k] = prim_wr && wr_data[NUM_DIRECT + k];
    end

    // Per-queue fields.
    for (genvar k = 0; k < NUM_QF; k++) begin : g_qf
        irq_field #(
            .W(NQ), .AW(AW),
            .ST_ADDR(A_SEC0 + qf_reg(k)),
            .MASK_ADDR(A_SMASK0 + qf_reg(k))
        ) u_field (
            .clk(clk), .rst_n(rst_n), .ev(qev[k]),
            .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_slice(wr_data[qf_hi(k) * NQ +: NQ]),
            .sum_clr(sum_clr[k]),
            .stat_o(f_stat[k]), .mask_o(f_mask[k]),
            .any_raw_o(f_raw[k]), .any_msk_o(f_msk[k])
        );
    end

    // Host-error field, upper part of secondary register 2.
    irq_field #(
        .W(HOST_W), .AW(AW),
        .ST_ADDR(A_SEC0 + HOST_SEC),
        .MASK_ADDR(A_SMASK0 + HOST_SEC)
    ) u_host (
        .clk(clk), .rst_n(rst_n), .ev(ev_host),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_slice(wr_data[NQ +: HOST_W]),
        .sum_clr(sum_clr[NUM_QF]),
        .stat_o(host_stat), .mask_o(host_mask),
        .any_raw_o(f_raw[NUM_QF]), .any_msk_o(f_msk[NUM_QF])
    );

    // Direct primary bits: write-one-to-clear, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) direct_q <= '0;
        else        direct_q <= (direct_q & ~(prim_wr ? wr_data[NUM_DIRECT-1:0] : '0)) | ev_prim;
    end

    // Primary mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) pmask_q <= '0;
        else if (wr_en && wr_addr == AW'(A_PMASK)) pmask_q <= wr_data[PRIM_W-1:0];
    end

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= 1'b0;
        else if (wr_en && wr_addr == AW'(A_GEN)) gen_q <= wr_data[0];
    end

    irq_summary #(.ND(NUM_DIRECT), .NSF(NSF)) u_sum (
        .direct_stat(direct_q), .f_raw(f_raw), .f_msk(f_msk),
        .pmask(pmask_q), .gen_en(gen_q),
        .pstat_o(pstat), .pend_o(pend), .irq_o(irq_o)
    );

    // Assemble secondary status and mask views from their fields.
    always_comb begin
        for (int r = 0; r < NUM_SEC; r++) begin
            sec_view[r]  = '0;
            smsk_view[r] = '0;
        end
        for (int k = 0; k < NUM_QF; k++) begin
            sec_view[qf_reg(k)][qf_hi(k) * NQ +: NQ]  = f_stat[k];
            smsk_view[qf_reg(k)][qf_hi(k) * NQ +: NQ] = f_mask[k];
        end
        sec_view[HOST_SEC][NQ +: HOST_W]  = host_stat;
        smsk_view[HOST_SEC][NQ +: HOST_W] = host_mask;
    end

    // Combinational read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_PSTAT))      rd_data = DW'(pstat);
        else if (rd_addr == AW'(A_PMASK)) rd_data = DW'(pmask_q);
        else if (rd_addr == AW'(A_GEN))   rd_data = DW'(gen_q);
        else if (rd_addr == AW'(A_PEND))  rd_data = DW'(pend);
        else begin
            for (int r = 0; r < NUM_SEC; r++) begin
                if (rd_addr == AW'(A_SEC0 + r))   rd_data = sec_view[r];
                if (rd_addr == AW'(A_SMASK0 + r)) rd_data = smsk_view[r];
            end
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: assertion checker for irq_aggregator, attached by bind below.
// Watches the transmit-OK field and the host field as representatives.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int  NQ = 4,
    localparam int DW = agg_dw(NQ)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NQ-1:0] ev_txok,
    input logic [NQ-1:0] stat0,
    input logic [2:0]    ev_host,
    input logic [2:0]    hstat,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          pend,
    input logic          gen,
    input logic          irq_o
);

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_txok) |=> ((stat0 & $past(ev_txok)) == $past(ev_txok)));

    assert_host_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_host) |=> ((hstat & $past(ev_host)) == $past(ev_host)));

    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat0 & ~$past(stat0) & ~$past(ev_txok)) == '0));

    assert_summary_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(A_PSTAT) && wr_data[NUM_DIRECT] && ev_txok == '0)
        |=> (stat0 == '0));

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(A_SEC0) && ((wr_data[NQ-1:0] & ev_txok) != '0))
        |=> ((stat0 & $past(ev_txok)) == $past(ev_txok)));

    assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !irq_o);

endmodule

bind irq_aggregator irq_aggregator_chk #(.NQ(NQ)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .ev_txok(ev_txok), .stat0(f_stat[0]),
    .ev_host(ev_host), .hstat(host_stat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pend(pend), .gen(gen_q), .irq_o(irq_o)
);

// File: tb/irq_aggregator_tb_top.sv
// Bench: sweeps fields, queues, clears and masks of irq_aggregator (NQ = 4).
module irq_aggregator_tb_top;

    localparam int NQ = 4;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bprim = '0;
    logic [NQ-1:0] bq [8];
    logic [2:0]    bhost = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_aggregator #(.NQ(NQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_prim(bprim),
        .ev_txok(bq[0]), .ev_desc(bq[1]), .ev_txerr(bq[2]), .ev_eol(bq[3]),
        .ev_urun(bq[4]), .ev_cbro(bq[5]), .ev_cbru(bq[6]), .ev_trig(bq[7]),
        .ev_host(bhost), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Layout from R2: register address and bit offset of field k.
    function automatic int faddr(input int k);
        case (k)
            0, 1: return 1;
            2, 3: return 2;
            4:    return 3;
            5, 6: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int flsb(input int k);
        return (k == 1 || k == 3 || k == 6) ? NQ : 0;
    endfunction

    // All implemented bits of secondary register at address a.
    function automatic logic [DW-1:0] full_of(input int a);
        case (a)
            3: return 12'h07F;
            5: return 12'h00F;
            default: return 12'h0FF;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        rd_addr = 4'(a);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input int k, input logic [NQ-1:0] bits);
        @(negedge clk);
        bq[k] = bits;
        @(negedge clk);
        bq[k] = '0;
    endtask

    task automatic fire_all();
        @(negedge clk);
        for (int k = 0; k < 8; k++) bq[k] = '1;
        bhost = '1; bprim = '1;
        @(negedge clk);
        for (int k = 0; k < 8; k++) bq[k] = '0;
        bhost = '0; bprim = '0;
    endtask

    task automatic clr_all();
        wr(0, 12'hFFF);
    endtask

    logic [DW-1:0] v;
    logic [DW-1:0] e;

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) bq[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every address and the output
        for (int a = 0; a < 14; a++) begin
            rd(a, v);
            check("R1", $sformatf("reset addr %0d", a), v, '0);
        end
        check("R1", "reset irq_o", 12'(irq_o), '0);

        // R2/R3: single-bit sweep over every field and queue
        for (int k = 0; k < 8; k++) begin
            for (int q = 0; q < NQ; q++) begin
                clr_all();
                fire(k, NQ'(1) << q);
                rd(faddr(k), v);
                check("R2", $sformatf("field %0d queue %0d", k, q), v, 12'(1) << (flsb(k) + q));
                rd(0, v);
                check("R3", $sformatf("summary of field %0d", k), v, 12'(1) << (3 + k));
            end
        end
        for (int h = 0; h < 3; h++) begin
            clr_all();
            @(negedge clk); bhost = 3'(1) << h;
            @(negedge clk); bhost = '0;
            rd(3, v);
            check("R2", $sformatf("host bit %0d", h), v, 12'(1) << (NQ + h));
            rd(0, v);
            check("R3", "host summary", v, 12'h800);
        end
        for (int d = 0; d < 3; d++) begin
            clr_all();
            @(negedge clk); bprim = 3'(1) << d;
            @(negedge clk); bprim = '0;
            rd(0, v);
            check("R3", $sformatf("direct bit %0d", d), v, 12'(1) << d);
        end

        // R4: partial secondary clear, then full clear drops the summary
        for (int k = 0; k < 8; k++) begin
            clr_all();
            fire(k, '1);
            wr(faddr(k), 12'(4'b0101) << flsb(k));
            rd(faddr(k), v);
            check("R4", $sformatf("partial clear field %0d", k), v, 12'(4'b1010) << flsb(k));
            rd(0, v);
            check("R4", "summary kept", v, 12'(1) << (3 + k));
            wr(faddr(k), 12'(4'b1010) << flsb(k));
            rd(0, v);
            check("R4", "summary dropped", v, '0);
        end

        // R5: summary clear wipes its field only
        for (int k = 0; k < 8; k++) begin
            clr_all();
            fire_all();
            wr(0, 12'(1) << (3 + k));
            rd(faddr(k), v);
            e = full_of(faddr(k)) & ~(12'hF << flsb(k));
            check("R5", $sformatf("summary clear field %0d", k), v, e);
            rd(0, v);
            check("R5", "primary after summary clear", v, 12'hFFF & ~(12'(1) << (3 + k)));
        end
        clr_all(); fire_all();
        wr(0, 12'h800);
        rd(3, v);
        check("R5", "host summary clear", v, 12'h00F);
        wr(0, 12'h005);
        rd(0, v);
        check("R5", "direct clear", v, 12'h7FA);

        // R6: event coinciding with a clear survives
        clr_all();
        fire(0, 4'b0010);
        @(negedge clk);
        bq[0] = 4'b0001; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 12'h003;
        @(negedge clk);
        bq[0] = '0; wr_en = 1'b0;
        rd(1, v);
        check("R6", "secondary clear vs event", v, 12'h001);
        clr_all();
        fire(2, 4'b0100);
        @(negedge clk);
        bq[2] = 4'b1000; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 12'h020;
        @(negedge clk);
        bq[2] = '0; wr_en = 1'b0;
        rd(2, v);
        check("R6", "summary clear vs event", v, 12'h008);
        rd(0, v);
        check("R6", "summary bit stays", v, 12'h020);
        clr_all();
        @(negedge clk);
        bprim = 3'b001; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 12'h001;
        @(negedge clk);
        bprim = '0; wr_en = 1'b0;
        rd(0, v);
        check("R6", "direct clear vs event", v, 12'h001);

        // R7: mask sweep over every primary bit and both mask levels
        wr(7, 12'h001);
        for (int p = 0; p < 12; p++) begin
            for (int pm = 0; pm < 2; pm++) begin
                for (int sm = 0; sm < 2; sm++) begin
                    clr_all();
                    wr(6, pm ? 12'(1) << p : 12'h000);
                    for (int a = 9; a < 14; a++) wr(a, sm ? 12'hFFF : 12'h000);
                    if (p < 3) begin
                        @(negedge clk); bprim = 3'(1) << p;
                        @(negedge clk); bprim = '0;
                    end else if (p < 11) begin
                        fire(p - 3, 4'b0001);
                    end else begin
                        @(negedge clk); bhost = 3'b001;
                        @(negedge clk); bhost = '0;
                    end
                    e = 12'((pm == 1) && (p < 3 || sm == 1));
                    rd(8, v);
                    check("R7", $sformatf("pending p=%0d pm=%0d sm=%0d", p, pm, sm), v, e);
                    check("R8", "irq follows pending when enabled", 12'(irq_o), e);
                end
            end
        end
        clr_all();
        wr(6, 12'h008);
        wr(9, 12'h002);
        fire(0, 4'b0001);
        rd(8, v);
        check("R7", "unmasked queue ignored", v, 12'h000);
        fire(0, 4'b0010);
        rd(8, v);
        check("R7", "masked queue pends", v, 12'h001);

        // R8: global disable silences output, keeps state
        clr_all();
        wr(6, 12'hFFF);
        @(negedge clk); bprim = 3'b001;
        @(negedge clk); bprim = '0;
        #1;
        check("R8", "irq enabled", 12'(irq_o), 12'h001);
        wr(7, 12'h000);
        #1;
        check("R8", "irq disabled", 12'(irq_o), 12'h000);
        rd(8, v);
        check("R8", "pending kept", v, 12'h001);
        rd(0, v);
        check("R8", "status kept", v, 12'h001);
        wr(7, 12'h001);
        #1;
        check("R8", "irq re-enabled", 12'(irq_o), 12'h001);

        // R9: mask/enable read-back, pending address write ignored
        wr(6, 12'hA5A);
        rd(6, v);
        check("R9", "primary mask", v, 12'hA5A);
        rd(7, v);
        check("R9", "global enable", v, 12'h001);
        for (int a = 9; a < 14; a++) begin
            wr(a, 12'hFFF);
            rd(a, v);
            check("R9", $sformatf("secondary mask %0d", a), v, full_of(a - 8));
        end
        clr_all();
        wr(8, 12'hFFF);
        rd(8, v);
        check("R9", "pending write ignored", v, 12'h000);
        rd(0, v);
        check("R9", "status untouched by pending write", v, 12'h000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule